// File: doc/BRIEF.md
# Procedure Linkage Return Stack

This unit performs the control-transfer side of subroutine linkage for a 16-bit processor with segmented code addresses. It owns a return-address stack held in a small internal word memory. When a call is executed, it saves the address of the instruction after the call. When a return is executed, it reads the saved words back into the code segment and instruction pointer outputs.

Each operation is presented on `op_valid` together with a 3-bit `op_code`. The same cycle carries:

- the current code segment,
- the sequential next instruction pointer,
- the target offset and segment from the instruction's immediate bytes,
- a general-register operand.

The stack grows downward in 16-bit words. Near operations move one word and finish in one cycle. Far operations move a two-word frame over two cycles, with `busy` asserted during the second cycle. A completed operation pulses `done` for one cycle, and the resulting code address is then on `new_cs:new_ip`.

Top module: `call_ret_stack`

## Requirements
- R1: Near call (op_code 0) pushes `next_ip`, loads `new_ip` from `tgt_off`, leaves `new_cs` unchanged, lowers `sp` by one and pulses `done` in the cycle after acceptance.
- R2: Register call (op_code 2) pushes `next_ip`, loads `new_ip` from `reg_val`, leaves `new_cs` unchanged and lowers `sp` by one.
- R3: Near return (op_code 3) loads `new_ip` from the top entry, leaves `new_cs` unchanged and raises `sp` by one, so execution resumes after the matching call.
- R4: Far call (op_code 1) takes two cycles. It pushes `cur_cs` first and `next_ip` second, lowering `sp` by two, and then loads `new_cs` from `tgt_seg` and `new_ip` from `tgt_off`.
- R5: Far return (op_code 4) takes two cycles. It pops the instruction pointer first and the code segment second, raising `sp` by two.
- R6: `busy` is high for exactly the cycle after a far operation is accepted. Any operation presented while `busy` is high is ignored. `done` pulses once per operation.
- R7: A word pushed when `sp` is 0 (full) is dropped, leaving `sp` and the stored entries unchanged, and sets the sticky `overflow` flag. The control transfer still takes place.
- R8: A word popped when `sp` equals DEPTH (empty) leaves `sp` unchanged. The register it would have restored keeps its value, and the sticky `underflow` flag is set.
- R9: Reset sets `sp` to DEPTH, clears `overflow`, `underflow`, `busy` and `done`, and loads `new_cs:new_ip` with the reset vector parameters.
- R10: The op_code values 5, 6 and 7 are ignored: no state changes and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | 0 near call, 1 far call, 2 register call, 3 near return, 4 far return |
| cur_cs | input | 16 | Current code segment |
| next_ip | input | 16 | Address of the instruction after the current one |
| tgt_off | input | 16 | Immediate target offset |
| tgt_seg | input | 16 | Immediate target segment |
| reg_val | input | 16 | General-register operand for a register call |
| new_cs | output | 16 | Resulting code segment |
| new_ip | output | 16 | Resulting instruction pointer |
| sp | output | clog2(DEPTH)+1 | Stack pointer; DEPTH means empty, 0 means full |
| busy | output | 1 | Second word of a far frame in progress |
| done | output | 1 | One-cycle pulse when an operation completes |
| overflow | output | 1 | Sticky push-on-full flag |
| underflow | output | 1 | Sticky pop-on-empty flag |

## Verification
Directed sequences are run first:

- Returns on an empty stack show that underflow keeps the instruction pointer and the code segment.
- A run of near calls past capacity, followed by a full unwind, shows whether dropped pushes spare the stored entries.
- A far call with a single free slot separates per-word overflow from whole-frame rejection.

A seeded random mix of all five operations and the unused codes then covers nesting orders that mixed near/far traffic produces. In this mix, a far return popping a near frame exposes any swap in push or pop word order. While `busy` is high, a conflicting request is held on the inputs, which shows whether the unit ignores it.

// File: rtl/call_ret_stack.sv
module call_ret_stack #(
  parameter int          DEPTH    = 16,
  parameter logic [15:0] RESET_CS = 16'hF000,
  parameter logic [15:0] RESET_IP = 16'hFFF0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic [15:0]                cur_cs,
  input  logic [15:0]                next_ip,
  input  logic [15:0]                tgt_off,
  input  logic [15:0]                tgt_seg,
  input  logic [15:0]                reg_val,
  output logic [15:0]                new_cs,
  output logic [15:0]                new_ip,
  output logic [$clog2(DEPTH):0]     sp,
  output logic                       busy,
  output logic                       done,
  output logic                       overflow,
  output logic                       underflow
);
  localparam int IW = $clog2(DEPTH);
  localparam int PW = IW + 1;
  localparam logic [PW-1:0] EMPTY = PW'(DEPTH);
  localparam logic [2:0] OP_NCALL = 3'd0, OP_FCALL = 3'd1, OP_RCALL = 3'd2,
                         OP_NRET  = 3'd3, OP_FRET  = 3'd4;

  logic [15:0] mem [DEPTH];
  logic [15:0] ip_hold, off_hold, seg_hold;
  logic        in_ret;

  wire accept = op_valid && !busy;
  wire full   = (sp == '0);
  wire empty  = (sp == EMPTY);

  wire push_en = (accept && (op_code == OP_NCALL || op_code == OP_FCALL || op_code == OP_RCALL))
              || (busy && !in_ret);
  wire pop_en  = (accept && (op_code == OP_NRET || op_code == OP_FRET)) || (busy && in_ret);

  wire [15:0] push_data = busy ? ip_hold : ((op_code == OP_FCALL) ? cur_cs : next_ip);
  wire [15:0] top       = mem[sp[IW-1:0]];
  wire [PW-1:0] sp_dn   = sp - 1'b1;

  always_ff @(posedge clk)
    if (push_en && !full) mem[sp_dn[IW-1:0]] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= EMPTY;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      busy      <= 1'b0;
      in_ret    <= 1'b0;
      done      <= 1'b0;
      new_cs    <= RESET_CS;
      new_ip    <= RESET_IP;
      ip_hold   <= '0;
      off_hold  <= '0;
      seg_hold  <= '0;
    end else begin
      done <= 1'b0;
      if (push_en) begin
        if (full) overflow <= 1'b1;
        else      sp <= sp_dn;
      end
      if (pop_en) begin
        if (empty) underflow <= 1'b1;
        else       sp <= sp + 1'b1;
      end
      if (accept) begin
        case (op_code)
          OP_NCALL: begin new_ip <= tgt_off; done <= 1'b1; end
          OP_RCALL: begin new_ip <= reg_val; done <= 1'b1; end
          OP_NRET: begin
            if (!empty) new_ip <= top;
            done <= 1'b1;
          end
          OP_FCALL: begin
            busy     <= 1'b1;
            in_ret   <= 1'b0;
            ip_hold  <= next_ip;
            off_hold <= tgt_off;
            seg_hold <= tgt_seg;
          end
          OP_FRET: begin
            busy   <= 1'b1;
            in_ret <= 1'b1;
            if (!empty) new_ip <= top;
          end
          default: ;
        endcase
      end else if (busy) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (in_ret) begin
          if (!empty) new_cs <= top;
        end else begin
          new_cs <= seg_hold;
          new_ip <= off_hold;
        end
      end
    end
  end

  a_r1_near_call_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_code == OP_NCALL && !full) |=> (sp == $past(sp) - 1'b1));
  a_r3_near_ret_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_code == OP_NRET && !empty) |=> (sp == $past(sp) + 1'b1));
  a_r6_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy && done));
  a_r6_cs_stable_near: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_code != OP_FCALL && op_code != OP_FRET) |=> $stable(new_cs));
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && full && !pop_en) |=> (sp == '0 && overflow));
  a_r8_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  a_r8_sp_range: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= EMPTY);
  a_r10_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_code > OP_FRET) |=> (!done && !busy && $stable(sp)));
endmodule

// File: tb/tb_call_ret_stack.sv
`timescale 1ns/1ps
module tb_call_ret_stack;
  localparam int D  = 16;
  localparam int PW = $clog2(D) + 1;
  localparam logic [15:0] RCS = 16'hF000, RIP = 16'hFFF0;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, op_valid;
  logic [2:0] op_code;
  logic [15:0] cur_cs, next_ip, tgt_off, tgt_seg, reg_val;
  logic [15:0] new_cs, new_ip;
  logic [PW-1:0] sp;
  logic busy, done, overflow, underflow;

  call_ret_stack #(.DEPTH(D), .RESET_CS(RCS), .RESET_IP(RIP)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cur_cs(cur_cs), .next_ip(next_ip), .tgt_off(tgt_off), .tgt_seg(tgt_seg),
    .reg_val(reg_val), .new_cs(new_cs), .new_ip(new_ip), .sp(sp), .busy(busy),
    .done(done), .overflow(overflow), .underflow(underflow));

  logic [15:0] mm [D];
  int  msp;
  logic [15:0] mcs, mip;
  bit  movf, munf, finished;
  int  total, bad;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic void mpush(logic [15:0] v);
    if (msp == 0) movf = 1'b1;
    else begin msp--; mm[msp] = v; end
  endfunction

  function automatic bit mpop(output logic [15:0] v);
    v = '0;
    if (msp == D) begin munf = 1'b1; return 1'b0; end
    v = mm[msp]; msp++;
    return 1'b1;
  endfunction

  task automatic check_all(string tag, bit exp_done);
    chk({tag, " cs"}, 32'(new_cs), 32'(mcs));
    chk({tag, " ip"}, 32'(new_ip), 32'(mip));
    chk({tag, " sp"}, 32'(sp), 32'(msp));
    chk({tag, " ovf"}, 32'(overflow), 32'(movf));
    chk({tag, " unf"}, 32'(underflow), 32'(munf));
    chk({tag, " done"}, 32'(done), 32'(exp_done));
    chk({tag, " busy"}, 32'(busy), 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0;
    cur_cs = '0; next_ip = '0; tgt_off = '0; tgt_seg = '0; reg_val = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    msp = D; movf = 0; munf = 0; mcs = RCS; mip = RIP;
    check_all("R9 reset", 1'b0);
  endtask

  task automatic run_op(logic [2:0] code, logic [15:0] nip, logic [15:0] off,
                        logic [15:0] seg, logic [15:0] rv, string tag);
    logic [15:0] v;
    op_valid = 1'b1; op_code = code; cur_cs = mcs; next_ip = nip;
    tgt_off = off; tgt_seg = seg; reg_val = rv;
    @(posedge clk); @(negedge clk);
    if (code == 3'd1 || code == 3'd4) begin
      chk({tag, " R6 busy"}, 32'(busy), 32'd1);
      chk({tag, " R6 no early done"}, 32'(done), 32'd0);
      op_code = 3'd0; tgt_off = ~off; next_ip = ~nip;
      @(posedge clk); @(negedge clk);
    end
    op_valid = 1'b0;
    case (code)
      3'd0: begin mpush(nip); mip = off; end
      3'd1: begin mpush(mcs); mpush(nip); mcs = seg; mip = off; end
      3'd2: begin mpush(nip); mip = rv; end
      3'd3: if (mpop(v)) mip = v;
      3'd4: begin
        if (mpop(v)) mip = v;
        if (mpop(v)) mcs = v;
      end
      default: ;
    endcase
    check_all(tag, code <= 3'd4);
  endtask

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd0: return "R1 near call";
      3'd1: return "R4 far call";
      3'd2: return "R2 reg call";
      3'd3: return "R3 near ret";
      3'd4: return "R5 far ret";
      default: return "R10 unused code";
    endcase
  endfunction

  initial begin
    total = 0; bad = 0; finished = 0;
    void'($urandom(32'd20240611));
    do_reset();

    run_op(3'd3, 16'h0, 16'h0, 16'h0, 16'h0, "R8 near ret empty");
    run_op(3'd4, 16'h0, 16'h0, 16'h0, 16'h0, "R8 far ret empty");
    run_op(3'd6, 16'h1, 16'h2, 16'h3, 16'h4, "R10 unused code 6");

    do_reset();
    run_op(3'd0, 16'h0103, 16'h0200, 16'h0, 16'h0, "R1 near call");
    run_op(3'd2, 16'h0205, 16'h0300, 16'h0, 16'hBEEF, "R2 reg call");
    run_op(3'd1, 16'hBEF2, 16'h0127, 16'hA300, 16'h0, "R4 far call");
    run_op(3'd4, 16'h0, 16'h0, 16'h0, 16'h0, "R5 far ret");
    run_op(3'd3, 16'h0, 16'h0, 16'h0, 16'h0, "R3 near ret");
    run_op(3'd3, 16'h0, 16'h0, 16'h0, 16'h0, "R3 near ret nested");

    do_reset();
    for (int i = 0; i < D + 2; i++)
      run_op(3'd0, 16'(16'h1000 + i), 16'(16'h2000 + i), 16'h0, 16'h0, "R7 fill past full");
    for (int i = 0; i < D; i++)
      run_op(3'd3, 16'h0, 16'h0, 16'h0, 16'h0, "R7 unwind entries intact");

    do_reset();
    for (int i = 0; i < D - 1; i++)
      run_op(3'd0, 16'(16'h3000 + i), 16'(16'h4000 + i), 16'h0, 16'h0, "R1 fill");
    run_op(3'd1, 16'h5555, 16'h6666, 16'h7777, 16'h0, "R7 far call one slot");
    run_op(3'd4, 16'h0, 16'h0, 16'h0, 16'h0, "R5 far ret after split frame");

    do_reset();
    for (int i = 0; i < 400; i++) begin
      logic [2:0] c;
      c = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      run_op(c, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom), tag_of(c));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule